// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle 32-bit load/store processor. It steps through a small set of states for each instruction. The first two states fetch the instruction and then decode it. After that it follows a short path that depends on the instruction class, and the last state of every path returns to fetch. In each state it drives the control lines of the datapath: PC update enables, the memory address select, memory read and write, the instruction register load, the register file write and its source and destination selects, the ALU input selects and the ALU operation class. The datapath, the memory and the ALU function decoder sit outside this block.

The machine is Moore-style. The control lines depend only on the current state, and they come straight from flip-flops. To make this work, the next state's control word is decoded and loaded on the same edge as the state register, so it costs no extra cycle. The opcode and function fields come from the instruction register and must stay stable from the decode state onward. The supported classes are register-register ALU operations, word load, word store, branch-if-equal, absolute jump, and jump-to-register. Jump-to-register is an ALU-class instruction with function code 8, and it loads the PC from the rs register through PC source 3.

Top module: `mcc_fsm`

## Requirements
- R1: A synchronous active-high reset puts the machine in the fetch state. While reset is high, and in the first cycle after it falls, the outputs show the fetch control word.
- R2: The fetch state asserts mem_rd, ir_wr and pc_wr. It drives addr_sel=0, alu_src_a=0, alu_src_b=01, alu_op=00 and pc_src=00. The next state is always decode.
- R3: The decode state drives alu_src_a=0, alu_src_b=11 and alu_op=00, with no enables. It dispatches on the opcode as follows: 35 or 43 to address compute, 0 to ALU execute (or jump-to-register), 4 to branch, and 2 to jump.
- R4: A load (opcode 35) runs through address compute (alu_src_a=1, alu_src_b=10), then memory read (mem_rd=1, addr_sel=1), then write-back (reg_wr=1, mem_to_reg=1, reg_dst=0). It takes 5 cycles from fetch to fetch.
- R5: A store (opcode 43) runs through address compute and then a memory write (mem_wr=1, addr_sel=1). It takes 4 cycles.
- R6: An ALU instruction (opcode 0, function other than 8) runs through execute (alu_src_a=1, alu_src_b=00, alu_op=10) and then write-back (reg_wr=1, reg_dst=1, mem_to_reg=0). It takes 4 cycles.
- R7: A branch (opcode 4) completes in one state with pc_wr_cond=1, alu_src_a=1, alu_src_b=00, alu_op=01 and pc_src=01. It takes 3 cycles.
- R8: A jump (opcode 2) completes in one state with pc_wr=1 and pc_src=10. It takes 3 cycles.
- R9: Opcode 0 with function 8 completes in one state with pc_wr=1 and pc_src=11. It takes 3 cycles. Function 8 has no effect with any other opcode.
- R10: Any other opcode returns from decode to fetch, for 2 cycles in total, and no write strobe is raised in its decode cycle.
- R11: Every enable and select that a state does not set is 0. The opcode and function inputs are ignored in every state except decode and address compute.
- R12: mem_rd and mem_wr are never high together, and neither are pc_wr and pc_wr_cond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | OP_W | Opcode field from the instruction register |
| fn_i | input | FN_W | Function field from the instruction register |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write if the ALU zero flag is set |
| addr_sel_o | output | 1 | Memory address select (0 = PC, 1 = ALU result register) |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_to_reg_o | output | 1 | Register write data select (1 = memory data register) |
| ir_wr_o | output | 1 | Instruction register load |
| pc_src_o | output | 2 | PC source (0 ALU, 1 ALU result reg, 2 jump target, 3 rs register) |
| alu_op_o | output | 2 | ALU operation class (0 add, 1 subtract, 2 by function field) |
| alu_src_a_o | output | 1 | ALU input A select (0 = PC, 1 = register A) |
| alu_src_b_o | output | 2 | ALU input B select (0 reg B, 1 constant 4, 2 immediate, 3 shifted immediate) |
| reg_wr_o | output | 1 | Register file write |
| reg_dst_o | output | 1 | Destination select (1 = rd, 0 = rt) |

## Verification
The assertions check the following on every cycle. The memory and PC strobes never collide. The fetch word carries its read, load and address select together, and fetch never lasts two cycles. A memory read from the data address is always followed by a load write-back. Every register write and every conditional PC write is followed by a fetch, and reset leaves the machine in fetch. Only the bench's scenarios can show the rest: the exact control word of each state, the dispatch for each opcode and function pair, the cycle count of each instruction class, the treatment of undefined opcodes, and that opcode changes outside decode and address compute have no effect. The bench shows these by comparing every cycle against its own model while it drives junk opcodes in the states that must ignore them. It also applies a reset in the middle of an instruction.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int ST_W    = 4;
  localparam int PSRC_W  = 2;
  localparam int AOP_W   = 2;
  localparam int SRCB_W  = 2;

  localparam int OPC_ALU   = 0;
  localparam int OPC_JMP   = 2;
  localparam int OPC_BEQ   = 4;
  localparam int OPC_LOAD  = 35;
  localparam int OPC_STORE = 43;
  localparam int FN_JREG   = 8;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_MREAD  = 4'd3,
    S_LDWB   = 4'd4,
    S_MWRITE = 4'd5,
    S_REXEC  = 4'd6,
    S_RWB    = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9,
    S_JREG   = 4'd10
  } state_t;

  typedef struct packed {
    logic              pc_wr;
    logic              pc_wr_cond;
    logic              addr_sel;
    logic              mem_rd;
    logic              mem_wr;
    logic              mem_to_reg;
    logic              ir_wr;
    logic [PSRC_W-1:0] pc_src;
    logic [AOP_W-1:0]  alu_op;
    logic              alu_src_a;
    logic [SRCB_W-1:0] alu_src_b;
    logic              reg_wr;
    logic              reg_dst;
  } ctrl_t;

endpackage

// File: rtl/mcc_next.sv
module mcc_next
  import mcc_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  state_t          state_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  output state_t          state_o
);

  localparam logic [OP_W-1:0] C_ALU   = OP_W'(OPC_ALU);
  localparam logic [OP_W-1:0] C_JMP   = OP_W'(OPC_JMP);
  localparam logic [OP_W-1:0] C_BEQ   = OP_W'(OPC_BEQ);
  localparam logic [OP_W-1:0] C_LOAD  = OP_W'(OPC_LOAD);
  localparam logic [OP_W-1:0] C_STORE = OP_W'(OPC_STORE);
  localparam logic [FN_W-1:0] C_JREG  = FN_W'(FN_JREG);

  logic is_jreg;
  assign is_jreg = (op_i == C_ALU) && (fn_i == C_JREG);

  always_comb begin
    state_o = S_FETCH;
    case (state_i)
      S_FETCH:  state_o = S_DECODE;
      S_DECODE: begin
        if (op_i == C_LOAD || op_i == C_STORE) state_o = S_MADDR;
        else if (is_jreg)                      state_o = S_JREG;
        else if (op_i == C_ALU)                state_o = S_REXEC;
        else if (op_i == C_BEQ)                state_o = S_BRANCH;
        else if (op_i == C_JMP)                state_o = S_JUMP;
        else                                   state_o = S_FETCH;
      end
      S_MADDR: begin
        if (op_i == C_LOAD)       state_o = S_MREAD;
        else if (op_i == C_STORE) state_o = S_MWRITE;
        else                      state_o = S_FETCH;
      end
      S_MREAD:  state_o = S_LDWB;
      S_REXEC:  state_o = S_RWB;
      default:  state_o = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_out.sv
module mcc_out
  import mcc_pkg::*;
(
  input  state_t state_i,
  output ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    case (state_i)
      S_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.ir_wr     = 1'b1;
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.alu_src_b = 2'b01;
      end
      S_DECODE: begin
        ctrl_o.alu_src_b = 2'b11;
      end
      S_MADDR: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_src_b = 2'b10;
      end
      S_MREAD: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      S_LDWB: begin
        ctrl_o.reg_wr     = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      S_MWRITE: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      S_REXEC: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_op    = 2'b10;
      end
      S_RWB: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.reg_dst = 1'b1;
      end
      S_BRANCH: begin
        ctrl_o.pc_wr_cond = 1'b1;
        ctrl_o.alu_src_a  = 1'b1;
        ctrl_o.alu_op     = 2'b01;
        ctrl_o.pc_src     = 2'b01;
      end
      S_JUMP: begin
        ctrl_o.pc_wr  = 1'b1;
        ctrl_o.pc_src = 2'b10;
      end
      S_JREG: begin
        ctrl_o.pc_wr  = 1'b1;
        ctrl_o.pc_src = 2'b11;
      end
      default: ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/mcc_fsm.sv
module mcc_fsm
  import mcc_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     op_i,
  input  logic [FN_W-1:0]     fn_i,
  output logic                pc_wr_o,
  output logic                pc_wr_cond_o,
  output logic                addr_sel_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic                mem_to_reg_o,
  output logic                ir_wr_o,
  output logic [PSRC_W-1:0]   pc_src_o,
  output logic [AOP_W-1:0]    alu_op_o,
  output logic                alu_src_a_o,
  output logic [SRCB_W-1:0]   alu_src_b_o,
  output logic                reg_wr_o,
  output logic                reg_dst_o
);

  state_t state_q;
  state_t state_nxt;
  state_t dec_sel;
  ctrl_t  ctrl_nxt;
  ctrl_t  ctrl_q;

  mcc_next #(.OP_W(OP_W), .FN_W(FN_W)) u_next (
    .state_i (state_q),
    .op_i    (op_i),
    .fn_i    (fn_i),
    .state_o (state_nxt)
  );

  // Decode the state being entered so the control word is a register.
  assign dec_sel = rst ? S_FETCH : state_nxt;

  mcc_out u_out (
    .state_i (dec_sel),
    .ctrl_o  (ctrl_nxt)
  );

  always_ff @(posedge clk) begin
    state_q <= dec_sel;
    ctrl_q  <= ctrl_nxt;
  end

  assign pc_wr_o      = ctrl_q.pc_wr;
  assign pc_wr_cond_o = ctrl_q.pc_wr_cond;
  assign addr_sel_o   = ctrl_q.addr_sel;
  assign mem_rd_o     = ctrl_q.mem_rd;
  assign mem_wr_o     = ctrl_q.mem_wr;
  assign mem_to_reg_o = ctrl_q.mem_to_reg;
  assign ir_wr_o      = ctrl_q.ir_wr;
  assign pc_src_o     = ctrl_q.pc_src;
  assign alu_op_o     = ctrl_q.alu_op;
  assign alu_src_a_o  = ctrl_q.alu_src_a;
  assign alu_src_b_o  = ctrl_q.alu_src_b;
  assign reg_wr_o     = ctrl_q.reg_wr;
  assign reg_dst_o    = ctrl_q.reg_dst;

endmodule

// File: rtl/mcc_fsm_chk.sv
module mcc_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       mem_to_reg,
  input logic       ir_wr,
  input logic       reg_wr
);

  // R12
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R12
  pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr && pc_wr_cond));

  // R1
  reset_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ir_wr);

  // R2
  fetch_word_chk: assert property (@(posedge clk) disable iff (rst)
    ir_wr |-> (mem_rd && pc_wr && !addr_sel));

  // R2
  fetch_single_chk: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> !ir_wr);

  // R4
  load_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (reg_wr && mem_to_reg));

  // R5
  store_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> addr_sel);

  // R6
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> ir_wr);

  // R7
  branch_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |=> ir_wr);

endmodule

bind mcc_fsm mcc_fsm_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .pc_wr      (pc_wr_o),
  .pc_wr_cond (pc_wr_cond_o),
  .addr_sel   (addr_sel_o),
  .mem_rd     (mem_rd_o),
  .mem_wr     (mem_wr_o),
  .mem_to_reg (mem_to_reg_o),
  .ir_wr      (ir_wr_o),
  .reg_wr     (reg_wr_o)
);

// File: tb/tb_mcc_fsm.sv
module tb_mcc_fsm;

  localparam int CLK_PERIOD = 10;
  localparam int OP_W       = 6;
  localparam int FN_W       = 6;
  localparam int N_RAND     = 1500;
  localparam int WD_LIMIT   = 100000;
  localparam int SEED       = 32'h1bad5eed;

  // bench state numbering
  localparam int T_F = 0, T_D = 1, T_MA = 2, T_MR = 3, T_LW = 4, T_SW = 5,
                 T_RX = 6, T_RW = 7, T_BR = 8, T_J = 9, T_JR = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [OP_W-1:0] op = '0;
  logic [FN_W-1:0] fn = '0;

  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, mem_to_reg, ir_wr;
  logic [1:0] pc_src, alu_op, alu_src_b;
  logic alu_src_a, reg_wr, reg_dst;

  mcc_fsm #(.OP_W(OP_W), .FN_W(FN_W)) dut (
    .clk (clk), .rst (rst), .op_i (op), .fn_i (fn),
    .pc_wr_o (pc_wr), .pc_wr_cond_o (pc_wr_cond), .addr_sel_o (addr_sel),
    .mem_rd_o (mem_rd), .mem_wr_o (mem_wr), .mem_to_reg_o (mem_to_reg),
    .ir_wr_o (ir_wr), .pc_src_o (pc_src), .alu_op_o (alu_op),
    .alu_src_a_o (alu_src_a), .alu_src_b_o (alu_src_b),
    .reg_wr_o (reg_wr), .reg_dst_o (reg_dst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  int ms     = T_F;

  // order: pcw pcc asel mrd mwr m2r irw psrc aop srca srcb rwr rdst
  function automatic logic [15:0] mk(int pcw, int pcc, int asel, int mrd,
      int mwr, int m2r, int irw, int ps, int ao, int sa, int sb, int rw, int rd);
    return {pcw[0], pcc[0], asel[0], mrd[0], mwr[0], m2r[0], irw[0],
            ps[1:0], ao[1:0], sa[0], sb[1:0], rw[0], rd[0]};
  endfunction

  function automatic logic [15:0] exp_ctl(int s);
    case (s)
      T_F:  return mk(1,0,0,1,0,0,1, 0,0,0,1, 0,0);
      T_D:  return mk(0,0,0,0,0,0,0, 0,0,0,3, 0,0);
      T_MA: return mk(0,0,0,0,0,0,0, 0,0,1,2, 0,0);
      T_MR: return mk(0,0,1,1,0,0,0, 0,0,0,0, 0,0);
      T_LW: return mk(0,0,0,0,0,1,0, 0,0,0,0, 1,0);
      T_SW: return mk(0,0,1,0,1,0,0, 0,0,0,0, 0,0);
      T_RX: return mk(0,0,0,0,0,0,0, 0,2,1,0, 0,0);
      T_RW: return mk(0,0,0,0,0,0,0, 0,0,0,0, 1,1);
      T_BR: return mk(0,1,0,0,0,0,0, 1,1,1,0, 0,0);
      T_J:  return mk(1,0,0,0,0,0,0, 2,0,0,0, 0,0);
      T_JR: return mk(1,0,0,0,0,0,0, 3,0,0,0, 0,0);
      default: return '0;
    endcase
  endfunction

  function automatic int exp_next(int s, int o, int f);
    case (s)
      T_F: return T_D;
      T_D: begin
        if (o == 35 || o == 43) return T_MA;
        if (o == 0 && f == 8)   return T_JR;
        if (o == 0)             return T_RX;
        if (o == 4)             return T_BR;
        if (o == 2)             return T_J;
        return T_F;
      end
      T_MA: return (o == 35) ? T_MR : ((o == 43) ? T_SW : T_F);
      T_MR: return T_LW;
      T_RX: return T_RW;
      default: return T_F;
    endcase
  endfunction

  function automatic int exp_lat(int o, int f);
    if (o == 35) return 5;
    if (o == 43) return 4;
    if (o == 0)  return (f == 8) ? 3 : 4;
    if (o == 4 || o == 2) return 3;
    return 2;
  endfunction

  function automatic string lat_tag(int o, int f);
    if (o == 35) return "R4";
    if (o == 43) return "R5";
    if (o == 0)  return (f == 8) ? "R9" : "R6";
    if (o == 4)  return "R7";
    if (o == 2)  return "R8";
    return "R10";
  endfunction

  function automatic string st_tag(int s);
    case (s)
      T_F: return "R2";
      T_D: return "R3";
      T_MA, T_MR, T_LW: return "R4";
      T_SW: return "R5";
      T_RX, T_RW: return "R6";
      T_BR: return "R7";
      T_J:  return "R8";
      T_JR: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check_word(string tag);
    logic [15:0] act;
    logic [15:0] expv;
    act  = {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, mem_to_reg, ir_wr,
            pc_src, alu_op, alu_src_a, alu_src_b, reg_wr, reg_dst};
    expv = exp_ctl(ms);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s state %0d: control actual=%b expected=%b", tag, ms, act, expv);
    end
    checks++;
    if ((mem_rd && mem_wr) || (pc_wr && pc_wr_cond)) begin
      errors++;
      $display("FAIL R12: strobes actual mrd=%0b mwr=%0b pcw=%0b pcc=%0b expected no pair",
               mem_rd, mem_wr, pc_wr, pc_wr_cond);
    end
  endtask

  // Entered at a negedge with the design in fetch; leaves at the next fetch.
  task automatic run_instr(input int o, input int f, input bit rst_mid, input bit after_rst);
    int  n;
    bit  junk;
    bit  aborted;
    junk    = 1'b0;
    aborted = 1'b0;
    check_word(after_rst ? "R1" : "R2");
    op = OP_W'(o);
    fn = FN_W'(f);
    ms = exp_next(ms, o, f);
    n  = 1;
    while (ms != T_F) begin
      @(negedge clk);
      check_word(junk ? {st_tag(ms), " R11"} : st_tag(ms));
      n++;
      junk = 1'b0;
      if (rst_mid && ms == T_RX) begin
        rst     = 1'b1;
        aborted = 1'b1;
        ms      = T_F;
      end else begin
        if (ms != T_D && ms != T_MA) begin
          op   = OP_W'($urandom);
          fn   = FN_W'($urandom);
          junk = 1'b1;
        end
        ms = exp_next(ms, int'(op), int'(fn));
      end
    end
    @(negedge clk);
    if (aborted) begin
      // R1: reset applied mid-instruction, design held in fetch
      check_word("R1");
      rst = 1'b0;
    end else begin
      checks++;
      if (n != exp_lat(o, f)) begin
        errors++;
        $display("FAIL %s latency op=%0d fn=%0d: actual=%0d expected=%0d",
                 lat_tag(o, f), o, f, n, exp_lat(o, f));
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_val;
    int r;
    int o;
    int f;
    seed_val = $urandom(SEED);
    rst = 1'b1;
    // R1: outputs held at fetch word during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      op = OP_W'($urandom);
      check_word("R1");
    end
    rst = 1'b0;
    ms  = T_F;

    // directed corners
    run_instr(35, 0, 1'b0, 1'b1);
    run_instr(43, 5, 1'b0, 1'b0);
    run_instr(0, 32, 1'b0, 1'b0);
    run_instr(4, 0, 1'b0, 1'b0);
    run_instr(2, 0, 1'b0, 1'b0);
    run_instr(0, 8, 1'b0, 1'b0);   // R9 jump to register
    run_instr(4, 8, 1'b0, 1'b0);   // R9 function 8 ignored for branch
    run_instr(2, 8, 1'b0, 1'b0);   // R9 function 8 ignored for jump
    run_instr(0, 9, 1'b0, 1'b0);   // R6 neighbour of 8
    run_instr(63, 0, 1'b0, 1'b0);  // R10 unknown opcode
    run_instr(1, 8, 1'b0, 1'b0);   // R10
    run_instr(0, 33, 1'b1, 1'b0);  // R1 reset in the middle of execute
    run_instr(35, 0, 1'b0, 1'b1);

    for (int k = 0; k < N_RAND; k++) begin
      r = int'($urandom % 8);
      f = int'($urandom % 64);
      case (r)
        0: o = 35;
        1: o = 43;
        2: begin o = 0; if (f == 8) f = 7; end
        3: o = 4;
        4: o = 2;
        5: begin o = 0; f = 8; end
        6: begin
          o = int'($urandom % 64);
          if (o == 0 || o == 2 || o == 4 || o == 35 || o == 43) o = 17;
        end
        default: o = 0;
      endcase
      run_instr(o, f, 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule